// File: doc/BRIEF.md
# Table-Driven Sine PWM Generator with Dead Time

This block produces the four gate drives of a single-phase full bridge from a sine reference that is held as a table. A carrier counter runs from 0 to `PERIOD-1` at a fixed switching rate. Each carrier period selects one table step, and `STEPS` steps make one output cycle. The carrier is therefore locked to the fundamental. With the default values (a 75 MHz timer clock, `PERIOD` = 4166, `STEPS` = 360) this gives an 18 kHz carrier and a 50 Hz output. Because the period count is truncated to an integer, the output frequency is slightly off nominal. That small error is accepted as it is.

The compare value for a step sits at half the period and moves by the sine of the step angle times the modulation index. A leg's reference is high while the counter is below the compare value. Leg B takes the inverse reference, which gives bipolar switching. Each leg passes through a dead-time state machine. That machine opens a gate only after its partner gate has been off for a programmable number of clocks.

The carrier state machine has two states, IDLE and RUN. The transition *start* (enable sampled high) leads from IDLE to RUN. The transition *stop* (enable sampled low) leads from RUN back to IDLE. RUN also holds two events: the period boundary and the table wrap.

Each leg has a gate state machine with three states: GAP (both gates off), HIGH and LOW. The transitions are:
- *turn-on*: GAP to HIGH or LOW, once the off count reaches the dead time. The reference chooses the side.
- *turn-off*: HIGH or LOW back to GAP, when the reference changes.
- *swap*: HIGH directly to LOW, or LOW directly to HIGH, taken only when the dead time is zero.
- *force-off*: any state to GAP, when the block is not running.

Top module: `spwm_gen`

## Requirements
- R1: While reset is asserted, and while enable has never been sampled high, all four gate outputs and both strobes are low.
- R2: In RUN the period strobe is high for exactly one cycle every `PERIOD` clocks. The first pulse comes in the first cycle after enable is sampled high.
- R3: The wrap strobe is high only together with a period strobe, on table step 0. Exactly `STEPS` period strobes lie between two wrap strobes.
- R4: In the period at step k, the leg-A high-side gate is high for cmp(k) − D clocks. Here cmp(k) = (PERIOD/2)·(1 + m·sin(2πk/STEPS)), within ±2 counts of fixed-point rounding, and D is the dead-time input in clocks. This holds when both phases of the reference are longer than D.
- R5: The leg-B high-side gate always equals the leg-A low-side gate, and the leg-B low-side gate always equals the leg-A high-side gate (inverse reference, bipolar switching).
- R6: The two gates of a leg are never high together. A gate turns on only after its partner has been low for at least D clocks.
- R7: If a reference phase is shorter than D, the gate pulse for that phase is suppressed.
- R8: The modulation input is an unsigned Q1.15 value: 32768 means m = 1.0, and larger codes clamp to 1.0. It is sampled only at start and on the clock edge that wraps the table, so a change takes effect from table step 0.
- R9: When enable is sampled low, all four gates are low from that edge on. On the next start, the counter and the table step restart at 0, so period and wrap strobes are high in the first cycle.
- R10: With D = 0 the gates swap without a gap, and the leg-A high-side time per period equals cmp(k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| mod_idx_i | input | 16 | Modulation index, unsigned Q1.15 |
| dead_cyc_i | input | 8 | Dead time in clock cycles |
| gate_ah_o | output | 1 | Leg A high-side gate |
| gate_al_o | output | 1 | Leg A low-side gate |
| gate_bh_o | output | 1 | Leg B high-side gate |
| gate_bl_o | output | 1 | Leg B low-side gate |
| period_stb_o | output | 1 | One-cycle pulse at each carrier period start |
| wrap_stb_o | output | 1 | One-cycle pulse at each table wrap |

## Verification
A new modulation index can arrive at the same edge on which the table wraps. The bench provokes this by changing the index in the very last clock of step `STEPS-1`. It then judges every duty of the following table cycle against the new, clamped index, and the duties of the cycle before against the old one. A second case is an index change placed mid-cycle. The bench expects that change to stay invisible until the next wrap.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    typedef enum logic [0:0] {
        CR_IDLE,
        CR_RUN
    } carrier_st_e;

    typedef enum logic [1:0] {
        DT_GAP,
        DT_HIGH,
        DT_LOW
    } gate_st_e;

    localparam int unsigned MOD_W   = 16;
    localparam int unsigned MOD_ONE = 32768;

endpackage

// File: rtl/spwm_sine_cmp.sv
module spwm_sine_cmp #(
    parameter int unsigned PERIOD = 4166,
    parameter int unsigned STEPS  = 360,
    parameter int unsigned IW     = $clog2(STEPS),
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic [IW-1:0]                idx_i,
    input  logic [spwm_pkg::MOD_W-1:0]   mod_i,
    output logic [CW-1:0]                cmp_o
);

    localparam int HALF = PERIOD / 2;

    logic signed [15:0] rom [STEPS];

    // Q1.15 sine samples, one per table step, computed at elaboration
    for (genvar g = 0; g < STEPS; g++) begin : g_rom
        localparam real ANG = 6.283185307179586 * real'(g) / real'(STEPS);
        assign rom[g] = 16'($rtoi($sin(ANG) * 32767.0));
    end

    logic signed [15:0] sel;
    logic signed [47:0] s_ext, m_ext, h_ext, prod, full;

    always_comb begin
        sel   = rom[idx_i];
        s_ext = 48'(sel);
        m_ext = $signed(48'(mod_i));
        h_ext = 48'(HALF);
        prod  = s_ext * m_ext * h_ext;
        full  = h_ext + (prod >>> 30);
        cmp_o = CW'(full);
    end

endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier
    import spwm_pkg::*;
#(
    parameter int unsigned PERIOD = 4166,
    parameter int unsigned STEPS  = 360,
    parameter int unsigned IW     = $clog2(STEPS),
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic             run_o,
    output logic [CW-1:0]    cnt_o,
    output logic [IW-1:0]    idx_o,
    output logic [MOD_W-1:0] mod_act_o,
    output logic             prd_stb_o,
    output logic             wrap_stb_o
);

    carrier_st_e      st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    idx_q;
    logic [MOD_W-1:0] m_q, m_clamp;
    logic             end_prd, end_tbl;

    assign end_prd = (cnt_q == CW'(PERIOD - 1));
    assign end_tbl = (idx_q == IW'(STEPS - 1));
    assign m_clamp = (mod_i > MOD_W'(MOD_ONE)) ? MOD_W'(MOD_ONE) : mod_i;

    // next state: start / stop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CR_IDLE: if (en_i)  st_d = CR_RUN;
            CR_RUN:  if (!en_i) st_d = CR_IDLE;
            default: st_d = CR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= CR_IDLE;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            idx_q <= '0;
            m_q   <= '0;
        end else if (st_q != CR_RUN || st_d != CR_RUN) begin
            cnt_q <= '0;
            idx_q <= '0;
            if (st_q == CR_IDLE && st_d == CR_RUN) m_q <= m_clamp;
        end else if (end_prd) begin
            cnt_q <= '0;
            if (end_tbl) begin
                idx_q <= '0;
                m_q   <= m_clamp;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        run_o      = (st_q == CR_RUN);
        cnt_o      = cnt_q;
        idx_o      = idx_q;
        mod_act_o  = m_q;
        prd_stb_o  = run_o && (cnt_q == '0);
        wrap_stb_o = prd_stb_o && (idx_q == '0);
    end

    // checker counters
    logic [CW-1:0] since_q;
    logic [IW:0]   nper_q;
    logic          seen_p_q, seen_w_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q  <= '0;
            nper_q   <= '0;
            seen_p_q <= 1'b0;
            seen_w_q <= 1'b0;
        end else if (!run_o) begin
            since_q  <= '0;
            nper_q   <= '0;
            seen_p_q <= 1'b0;
            seen_w_q <= 1'b0;
        end else begin
            since_q <= prd_stb_o ? CW'(1) : since_q + 1'b1;
            if (prd_stb_o) seen_p_q <= 1'b1;
            if (wrap_stb_o) begin
                nper_q   <= (IW + 1)'(1);
                seen_w_q <= 1'b1;
            end else if (prd_stb_o) begin
                nper_q <= nper_q + 1'b1;
            end
        end
    end

    a_r2_period_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && seen_p_q && prd_stb_o) |-> (since_q == CW'(PERIOD)));

    a_r3_steps_per_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && seen_w_q && wrap_stb_o) |-> (nper_q == (IW + 1)'(STEPS)));

    a_r8_mod_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && !(end_prd && end_tbl)) |=> $stable(m_q));

    a_r8_mod_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_o |-> (m_q <= MOD_W'(MOD_ONE)));

endmodule

// File: rtl/spwm_deadtime.sv
module spwm_deadtime
    import spwm_pkg::*;
#(
    parameter int unsigned DTW = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           act_i,
    input  logic           ref_i,
    input  logic [DTW-1:0] dt_i,
    output logic           hi_o,
    output logic           lo_o
);

    gate_st_e       st_q, st_d;
    logic [DTW-1:0] gcnt_q, gcnt_d;

    // next state: turn-on / turn-off / swap / force-off
    always_comb begin
        st_d   = st_q;
        gcnt_d = gcnt_q;
        if (!act_i) begin
            st_d   = DT_GAP;
            gcnt_d = '0;
        end else begin
            unique case (st_q)
                DT_HIGH: if (!ref_i) begin
                    if (dt_i == '0) st_d = DT_LOW;
                    else begin
                        st_d   = DT_GAP;
                        gcnt_d = DTW'(1);
                    end
                end
                DT_LOW: if (ref_i) begin
                    if (dt_i == '0) st_d = DT_HIGH;
                    else begin
                        st_d   = DT_GAP;
                        gcnt_d = DTW'(1);
                    end
                end
                DT_GAP: begin
                    if (gcnt_q >= dt_i) st_d = ref_i ? DT_HIGH : DT_LOW;
                    else                gcnt_d = gcnt_q + 1'b1;
                end
                default: st_d = DT_GAP;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= DT_GAP;
            gcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            gcnt_q <= gcnt_d;
        end
    end

    // outputs
    always_comb begin
        hi_o = (st_q == DT_HIGH);
        lo_o = (st_q == DT_LOW);
    end

    // checker: cycles each gate has been off, saturating
    logic [DTW-1:0] hi_off_q, lo_off_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_off_q <= '1;
            lo_off_q <= '1;
        end else begin
            hi_off_q <= hi_o ? '0 : ((hi_off_q == '1) ? hi_off_q : hi_off_q + 1'b1);
            lo_off_q <= lo_o ? '0 : ((lo_off_q == '1) ? lo_off_q : lo_off_q + 1'b1);
        end
    end

    a_r6_hi_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hi_o) |-> (lo_off_q >= dt_i));

    a_r6_lo_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lo_o) |-> (hi_off_q >= dt_i));

endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
    parameter int unsigned PERIOD = 4166,
    parameter int unsigned STEPS  = 360,
    parameter int unsigned DTW    = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           en_i,
    input  logic [15:0]    mod_idx_i,
    input  logic [DTW-1:0] dead_cyc_i,
    output logic           gate_ah_o,
    output logic           gate_al_o,
    output logic           gate_bh_o,
    output logic           gate_bl_o,
    output logic           period_stb_o,
    output logic           wrap_stb_o
);

    localparam int unsigned IW = $clog2(STEPS);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic          run;
    logic [CW-1:0] cnt, cmp;
    logic [IW-1:0] idx;
    logic [15:0]   mod_act;
    logic          ref_a;
    logic [1:0]    leg_ref, leg_hi, leg_lo;

    spwm_carrier #(.PERIOD(PERIOD), .STEPS(STEPS), .IW(IW), .CW(CW)) u_carrier (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .mod_i      (mod_idx_i),
        .run_o      (run),
        .cnt_o      (cnt),
        .idx_o      (idx),
        .mod_act_o  (mod_act),
        .prd_stb_o  (period_stb_o),
        .wrap_stb_o (wrap_stb_o)
    );

    spwm_sine_cmp #(.PERIOD(PERIOD), .STEPS(STEPS), .IW(IW), .CW(CW)) u_cmp (
        .idx_i (idx),
        .mod_i (mod_act),
        .cmp_o (cmp)
    );

    assign ref_a   = run && (cnt < cmp);
    assign leg_ref = {~ref_a, ref_a};

    for (genvar l = 0; l < 2; l++) begin : g_leg
        spwm_deadtime #(.DTW(DTW)) u_dt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .act_i  (run && en_i),
            .ref_i  (leg_ref[l]),
            .dt_i   (dead_cyc_i),
            .hi_o   (leg_hi[l]),
            .lo_o   (leg_lo[l])
        );
    end

    assign gate_ah_o = leg_hi[0];
    assign gate_al_o = leg_lo[0];
    assign gate_bh_o = leg_hi[1];
    assign gate_bl_o = leg_lo[1];

    a_r9_disable_gates_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));

    a_r5_leg_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_bh_o == gate_al_o) && (gate_bl_o == gate_ah_o));

    a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gate_ah_o && gate_al_o) && !(gate_bh_o && gate_bl_o));

endmodule

// File: tb/spwm_gen_tb_top.sv
module spwm_gen_tb_top;

    localparam int P = 100;
    localparam int S = 360;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [15:0] mod = '0;
    logic [7:0] dt = '0;
    logic ah, al, bh, bl, pstb, wstb;

    always #4 clk = ~clk;

    spwm_gen #(.PERIOD(P), .STEPS(S), .DTW(8)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .en_i (en),
        .mod_idx_i (mod), .dead_cyc_i (dt),
        .gate_ah_o (ah), .gate_al_o (al), .gate_bh_o (bh), .gate_bl_o (bl),
        .period_stb_o (pstb), .wrap_stb_o (wstb)
    );

    typedef struct {
        int    k;
        real   m;
        int    d;
        string tag;
    } exp_t;

    exp_t q[$];
    int tests = 0, fails = 0;
    int ovl_err = 0, gap_err = 0, mir_err = 0, spc_err = 0, wrp_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // driver side: push expected periods
    task automatic push(input int n, input real m, input int d, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t it;
            it.k = k % S; it.m = m; it.d = d;
            it.tag = (tag == "R8" && k < 150) ? "R4" : tag;
            q.push_back(it);
        end
    endtask

    // monitor
    int  hi_cnt = 0, since = 0, nper = 0, ah_off = 1000, al_off = 1000;
    bit  win = 0, seen_p = 0, seen_w = 0, ah_prev = 0, al_prev = 0;

    always @(negedge clk) begin
        if (!rst_n || !en) begin
            win = 0; seen_p = 0; seen_w = 0; hi_cnt = 0; since = 0; nper = 0;
        end else begin
            if ((ah && al) || (bh && bl)) ovl_err++;
            if (bh != al || bl != ah) mir_err++;
            if (ah && !ah_prev && al_off < int'(dt)) gap_err++;
            if (al && !al_prev && ah_off < int'(dt)) gap_err++;
            if (wstb && !pstb) wrp_err++;
            if (pstb) begin
                if (seen_p && since != P) spc_err++;
                since = 0;
                seen_p = 1;
                if (win) begin
                    if (q.size() == 0) chk(0, "R4 extra period", 1, 0);
                    else begin
                        exp_t it;
                        real e;
                        it = q.pop_front();
                        e = (P / 2.0) * (1.0 + it.m * $sin(6.283185307179586 * it.k / S));
                        if (it.d > 0 && e + 2.0 < it.d)
                            chk(hi_cnt == 0, "R7", hi_cnt, 0);
                        else if (e >= it.d + 4 && (P - e) >= it.d + 4) begin
                            int ex;
                            ex = $rtoi(e - it.d + 0.5);
                            chk(hi_cnt >= ex - 2 && hi_cnt <= ex + 2,
                                (it.d == 0) ? "R10" : it.tag, hi_cnt, ex);
                        end
                    end
                end
                win = 1;
                hi_cnt = 0;
                nper++;
            end
            if (wstb) begin
                if (seen_w) chk(nper - 1 == S, "R3", nper - 1, S);
                seen_w = 1;
                nper = 1;
            end
            hi_cnt += int'(ah);
            since++;
        end
        ah_off = ah ? 0 : ah_off + 1;
        al_off = al ? 0 : al_off + 1;
        ah_prev = ah;
        al_prev = al;
    end

    int cur = 0;
    task automatic wait_to(input int n);
        repeat (n - cur) @(posedge clk);
        #1;
        cur = n;
    endtask

    task automatic start_run();
        @(posedge clk); #1 en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pstb == 1'b1, "R2 first strobe", int'(pstb), 1);
        chk(wstb == 1'b1, "R9 restart at step 0", int'(wstb), 1);
        cur = 0;
    endtask

    task automatic stop_run();
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({ah, al, bh, bl} == 4'b0, "R9 gates off", int'({ah, al, bh, bl}), 0);
        chk(q.size() == 0, "R4 all periods seen", q.size(), 0);
        q.delete();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({ah, al, bh, bl, pstb, wstb} == 6'b0, "R1 in reset", int'({ah, al, bh, bl, pstb, wstb}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({ah, al, bh, bl, pstb, wstb} == 6'b0, "R1 idle", int'({ah, al, bh, bl, pstb, wstb}), 0);

        // phase 1: m=0.5, mid-cycle change, then change on the wrap edge
        dt = 8'd3; mod = 16'd16384;
        push(S, 0.5, 3, "R8");
        push(S, 0.75, 3, "R4");
        begin
            exp_t it;
            for (int k = 0; k < 100; k++) begin
                it.k = k; it.m = 1.0; it.d = 3; it.tag = "R8";
                q.push_back(it);
            end
        end
        start_run();
        wait_to(150 * P);  mod = 16'd24576;
        wait_to(720 * P - 1); mod = 16'd40000;
        wait_to(820 * P + 50);
        stop_run();

        // phase 2: long dead time, trough pulses suppressed
        dt = 8'd20; mod = 16'd24576;
        push(300, 0.75, 20, "R4");
        start_run();
        wait_to(300 * P + 50);
        stop_run();

        // phase 3: zero dead time
        dt = 8'd0; mod = 16'd16384;
        push(20, 0.5, 0, "R10");
        start_run();
        wait_to(20 * P + 50);
        stop_run();

        chk(ovl_err == 0, "R6 overlap", ovl_err, 0);
        chk(gap_err == 0, "R6 dead time", gap_err, 0);
        chk(mir_err == 0, "R5 leg mirror", mir_err, 0);
        chk(spc_err == 0, "R2 spacing", spc_err, 0);
        chk(wrp_err == 0, "R3 wrap alone", wrp_err, 0);
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

endmodule